// File: doc/BRIEF.md
# Watermarked Queue Controller with Selectable Interrupt

This block manages one circular queue of data words held in an internal memory. A configuration word sets the buffer size (16, 32, 64 or 128 words) and two watermark codes. One code defines when the queue counts as nearly empty and the other when it counts as nearly full. The controller keeps its own read and write pointers and a fill count. From these it derives four level flags. It also keeps two sticky error flags: one for a pop from an empty queue and one for a push into a full queue.

Any agent can push one word per cycle and pop one word per cycle, and both may happen in the same cycle. A popped word appears on the cycle after the request, together with a one-cycle valid strobe. A small register port gives access to the configuration word, the status bits and the interrupt controls. A 3-bit source code picks one of eight level conditions. Each condition is tied to the kind of access that preceded it. When the picked condition holds after such an access, a sticky interrupt status bit is set. The interrupt output shows that bit only while it is enabled.

Top module: `wmq_ctrl`

## Requirements
- R1: After reset the status register (address 1) reads 0x03, the configuration word (address 0) reads 0, the interrupt control register (address 2) reads 0, the interrupt status register (address 3) reads 1, `irq` is low and `pop_valid` is low.
- R2: Accepted pushes leave through pops in arrival order. `pop_valid` is high, and `pop_data` holds the word, in the cycle after a pop request.
- R3: A push while full (status bit 3) stores nothing, leaves the pointers alone and sets the sticky overflow flag, status bit 5.
- R4: A pop while empty (status bit 0) returns zero, leaves the pointers alone and sets the sticky underflow flag, status bit 4. Both sticky flags stay set until the next configuration write.
- R5: Configuration bits 25:24 hold a size code c, and the buffer holds 16 << c words. The write and read pointers read back in configuration bits 6:0 and 13:7 and wrap modulo the buffer size. Bits 23:22 hold an entry-size code that is stored and read back. Bits 21:14 read as zero.
- R6: Status bit 1 (nearly empty) is high when the fill count is at most 2^NE - 1, where NE sits in configuration bits 28:26.
- R7: Status bit 2 (nearly full) is high when the free space is at most 2^NF - 1, where NF sits in configuration bits 31:29. Bit 3 is high when the fill count equals the buffer size. Bit 0 is high when the fill count is zero.
- R8: Interrupt control bits 2:0 select the source. The read-kind sources are 0 = empty, 1 = nearly empty, 6 = not nearly full and 7 = not full. The write-kind sources are 2 = nearly full, 3 = full, 4 = not empty and 5 = not nearly empty. A read-kind source is tested only in the cycle after a pop request, and a write-kind source only in the cycle after a push request; rejected requests count as accesses. When the tested source holds, the interrupt status bit is set on that cycle's clock edge.
- R9: The interrupt status bit (address 3, bit 0) is sticky and is cleared by writing 1 to it. `irq` equals that bit ANDed with the enable bit, interrupt control bit 3.
- R10: A write to the configuration word sets both pointers and the fill count to zero and clears both sticky flags. A push or pop requested in the same cycle is dropped.
- R11: A push and a pop in the same cycle are both judged against the fill count from before the cycle. A pop on an empty queue therefore underflows while the push is stored, and on a non-empty, non-full queue the fill count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push request |
| push_data | input | DATA_W | Word to push |
| pop_req | input | 1 | Pop request |
| pop_valid | output | 1 | Pop result strobe, one cycle after a request |
| pop_data | output | DATA_W | Popped word, zero on underflow |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 config, 1 status, 2 irq control, 3 irq status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A push and a pop can land in the same cycle, and that cycle can also be an underflow. The bench provokes this by requesting both on an empty queue, then again on a partly filled one. It judges the result with its reference queue and the status register: the underflow flag must be set, the pushed word must be kept, and the fill count must stay unchanged in the second case. A configuration write that collides with a push is also provoked. The bench checks that the push is dropped and that the flags come back clean.

// File: rtl/wmq_pkg.sv
package wmq_pkg;

   // register select codes on the register port
   localparam logic [1:0] REG_CFG   = 2'd0;
   localparam logic [1:0] REG_STAT  = 2'd1;
   localparam logic [1:0] REG_IRQC  = 2'd2;
   localparam logic [1:0] REG_IRQS  = 2'd3;

   // level flags, bit 0 = empty ... bit 3 = full
   typedef struct packed {
      logic full;
      logic nfull;
      logic nempty;
      logic empty;
   } lvl_t;

   typedef enum logic [2:0] {
      SRC_EMPTY_RD     = 3'd0,
      SRC_NEMPTY_RD    = 3'd1,
      SRC_NFULL_WR     = 3'd2,
      SRC_FULL_WR      = 3'd3,
      SRC_NOTEMPTY_WR  = 3'd4,
      SRC_NOTNEMPTY_WR = 3'd5,
      SRC_NOTNFULL_RD  = 3'd6,
      SRC_NOTFULL_RD   = 3'd7
   } irq_src_e;

   // condition of one source given the level and the previous access kind
   function automatic logic src_holds(irq_src_e s, lvl_t l, logic was_rd, logic was_wr);
      case (s)
         SRC_EMPTY_RD:     return was_rd &  l.empty;
         SRC_NEMPTY_RD:    return was_rd &  l.nempty;
         SRC_NFULL_WR:     return was_wr &  l.nfull;
         SRC_FULL_WR:      return was_wr &  l.full;
         SRC_NOTEMPTY_WR:  return was_wr & ~l.empty;
         SRC_NOTNEMPTY_WR: return was_wr & ~l.nempty;
         SRC_NOTNFULL_RD:  return was_rd & ~l.nfull;
         default:          return was_rd & ~l.full;
      endcase
   endfunction

endpackage

// File: rtl/wmq_store.sv
module wmq_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 128,
   parameter int PTR_W  = $clog2(DEPTH),
   parameter int CNT_W  = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [CNT_W-1:0]  size_words,
   input  logic              push_do,
   input  logic              pop_do,
   input  logic [DATA_W-1:0] push_data,
   output logic [DATA_W-1:0] head_data,
   output logic [PTR_W-1:0]  wr_ptr,
   output logic [PTR_W-1:0]  rd_ptr,
   output logic [CNT_W-1:0]  count
);

   logic [DATA_W-1:0] mem [DEPTH];

   function automatic logic [PTR_W-1:0] step_ptr(logic [PTR_W-1:0] p, logic [CNT_W-1:0] lim);
      logic [CNT_W-1:0] nx;
      nx = {1'b0, p} + CNT_W'(1);
      return (nx >= lim) ? '0 : nx[PTR_W-1:0];
   endfunction

   always_ff @(posedge clk) begin
      if (push_do) mem[wr_ptr] <= push_data;
   end

   assign head_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_do) wr_ptr <= step_ptr(wr_ptr, size_words);
         if (pop_do)  rd_ptr <= step_ptr(rd_ptr, size_words);
         case ({push_do, pop_do})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/wmq_level.sv
module wmq_level
   import wmq_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] size_words,
   input  logic [2:0]       ne_code,
   input  logic [2:0]       nf_code,
   output lvl_t             lvl
);

   logic [CNT_W-1:0] ne_lim;
   logic [CNT_W-1:0] nf_lim;
   logic [CNT_W-1:0] free_words;

   // 2^code - 1, saturating to all ones when wider than the counter
   always_comb begin
      ne_lim     = CNT_W'((32'd1 << ne_code) - 32'd1);
      nf_lim     = CNT_W'((32'd1 << nf_code) - 32'd1);
      free_words = size_words - count;
      lvl.empty  = (count == '0);
      lvl.nempty = (count <= ne_lim);
      lvl.nfull  = (free_words <= nf_lim);
      lvl.full   = (count == size_words);
   end

endmodule

// File: rtl/wmq_irq.sv
module wmq_irq
   import wmq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  lvl_t     lvl,
   input  logic     last_rd,
   input  logic     last_wr,
   input  irq_src_e sel,
   input  logic     en,
   input  logic     clr_w1c,
   output logic     irq_stat,
   output logic     irq
);

   logic [7:0] hit;

   for (genvar k = 0; k < 8; k++) begin : g_src
      assign hit[k] = (sel == irq_src_e'(k)) &&
                      src_holds(irq_src_e'(k), lvl, last_rd, last_wr);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        irq_stat <= 1'b1;
      else if (|hit)     irq_stat <= 1'b1;
      else if (clr_w1c)  irq_stat <= 1'b0;
   end

   assign irq = irq_stat & en;

endmodule

// File: rtl/wmq_ctrl.sv
module wmq_ctrl
   import wmq_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int MIN_WORDS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_valid,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop_req,
   output logic              pop_valid,
   output logic [DATA_W-1:0] pop_data,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq
);

   localparam int DEPTH = MIN_WORDS << 3;
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   if (DATA_W < 1) begin : g_bad_width
      $error("wmq_ctrl: DATA_W must be positive");
   end
   if (MIN_WORDS < 2 || (MIN_WORDS & (MIN_WORDS - 1)) != 0) begin : g_bad_min
      $error("wmq_ctrl: MIN_WORDS must be a power of two of at least 2");
   end
   if (DEPTH > 128) begin : g_bad_depth
      $error("wmq_ctrl: largest buffer must fit the 7-bit pointer fields");
   end

   logic [1:0]       cfg_es;
   logic [1:0]       cfg_bs;
   logic [2:0]       cfg_ne;
   logic [2:0]       cfg_nf;
   irq_src_e         irq_sel;
   logic             irq_en;
   logic             uf;
   logic             of;
   logic             last_rd;
   logic             last_wr;
   logic             irq_stat;
   logic             cfg_wr;
   logic             irq_clr;
   logic             push_do;
   logic             pop_do;
   logic [CNT_W-1:0] size_words;
   logic [CNT_W-1:0] count;
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic [DATA_W-1:0] head_data;
   lvl_t             lvl;
   logic             unused_wbits;

   assign cfg_wr     = reg_wr && (reg_addr == REG_CFG);
   assign irq_clr    = reg_wr && (reg_addr == REG_IRQS) && reg_wdata[0];
   assign size_words = CNT_W'(MIN_WORDS) << cfg_bs;
   assign push_do    = push_valid & ~lvl.full  & ~cfg_wr;
   assign pop_do     = pop_req    & ~lvl.empty & ~cfg_wr;
   assign unused_wbits = ^{reg_wdata[21:4], reg_wdata[31:30]} ^ reg_wdata[29];

   wmq_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .PTR_W  (PTR_W),
      .CNT_W  (CNT_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (cfg_wr),
      .size_words (size_words),
      .push_do    (push_do),
      .pop_do     (pop_do),
      .push_data  (push_data),
      .head_data  (head_data),
      .wr_ptr     (wr_ptr),
      .rd_ptr     (rd_ptr),
      .count      (count)
   );

   wmq_level #(.CNT_W(CNT_W)) u_level (
      .count      (count),
      .size_words (size_words),
      .ne_code    (cfg_ne),
      .nf_code    (cfg_nf),
      .lvl        (lvl)
   );

   wmq_irq u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl),
      .last_rd  (last_rd),
      .last_wr  (last_wr),
      .sel      (irq_sel),
      .en       (irq_en),
      .clr_w1c  (irq_clr),
      .irq_stat (irq_stat),
      .irq      (irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_es    <= '0;
         cfg_bs    <= '0;
         cfg_ne    <= '0;
         cfg_nf    <= '0;
         irq_sel   <= SRC_EMPTY_RD;
         irq_en    <= 1'b0;
         uf        <= 1'b0;
         of        <= 1'b0;
         last_rd   <= 1'b0;
         last_wr   <= 1'b0;
         pop_valid <= 1'b0;
         pop_data  <= '0;
      end else begin
         last_rd   <= pop_req    & ~cfg_wr;
         last_wr   <= push_valid & ~cfg_wr;
         pop_valid <= pop_req    & ~cfg_wr;
         if (pop_req && !cfg_wr) pop_data <= pop_do ? head_data : '0;
         if (cfg_wr) begin
            cfg_es <= reg_wdata[23:22];
            cfg_bs <= reg_wdata[25:24];
            cfg_ne <= reg_wdata[28:26];
            cfg_nf <= reg_wdata[31:29];
            uf     <= 1'b0;
            of     <= 1'b0;
         end else begin
            if (pop_req && lvl.empty)   uf <= 1'b1;
            if (push_valid && lvl.full) of <= 1'b1;
         end
         if (reg_wr && reg_addr == REG_IRQC) begin
            irq_sel <= irq_src_e'(reg_wdata[2:0]);
            irq_en  <= reg_wdata[3];
         end
      end
   end

   always_comb begin
      case (reg_addr)
         REG_CFG:  reg_rdata = {cfg_nf, cfg_ne, cfg_bs, cfg_es, 8'h00,
                                7'(rd_ptr), 7'(wr_ptr)};
         REG_STAT: reg_rdata = {26'd0, of, uf, lvl};
         REG_IRQC: reg_rdata = {28'd0, irq_en, irq_sel};
         default:  reg_rdata = {31'd0, irq_stat};
      endcase
   end

endmodule

// File: rtl/wmq_ctrl_chk.sv
module wmq_ctrl_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             push_valid,
   input logic             pop_req,
   input logic             cfg_wr,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] size_words,
   input logic [3:0]       lvl,
   input logic             uf,
   input logic             of,
   input logic             last_rd,
   input logic [2:0]       irq_sel,
   input logic             irq_stat,
   input logic             irq_en,
   input logic             irq
);

   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      count <= size_words);

   p_empty_full_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(lvl[0] && lvl[3]));

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && lvl[3] && !pop_req && !cfg_wr) |=> ($stable(count) && of));

   p_underflow_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && lvl[0] && !cfg_wr) |=> uf);

   p_uf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (uf && !cfg_wr) |=> uf);

   p_cfg_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (count == '0 && !uf && !of));

   p_empty_rd_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (last_rd && irq_sel == 3'd0 && lvl[0]) |=> irq_stat);

   p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);

endmodule

bind wmq_ctrl wmq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .push_valid (push_valid),
   .pop_req    (pop_req),
   .cfg_wr     (cfg_wr),
   .count      (count),
   .size_words (size_words),
   .lvl        (lvl),
   .uf         (uf),
   .of         (of),
   .last_rd    (last_rd),
   .irq_sel    (irq_sel),
   .irq_stat   (irq_stat),
   .irq_en     (irq_en),
   .irq        (irq)
);

// File: tb/sim_wmq_ctrl.sv
module sim_wmq_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push_valid = 1'b0;
   logic [31:0] push_data = '0;
   logic        pop_req = 1'b0;
   logic        pop_valid;
   logic [31:0] pop_data;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;

   // reference model
   logic [31:0] exp_q[$];
   logic [31:0] res_q[$];
   int m_size = 16, m_ne = 0, m_nf = 0, m_bs = 0, m_es = 0;
   int m_wr = 0, m_rd = 0;
   bit m_uf = 0, m_of = 0;

   always #5 clk = ~clk;

   wmq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
      .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // monitor: compares each pop result with the scoreboard
   always @(negedge clk) begin
      if (rst_n && pop_valid) begin
         if (res_q.size() == 0) check(1'b0, "R2 unexpected pop_valid", pop_data, 32'h0);
         else begin
            logic [31:0] e;
            e = res_q.pop_front();
            check(pop_data === e, "R2/R4 pop_data", pop_data, e);
         end
      end
   end

   task automatic step(input bit pu, input logic [31:0] d, input bit po);
      int pre;
      pre = exp_q.size();
      @(negedge clk);
      push_valid = pu; push_data = d; pop_req = po;
      if (po) begin
         if (pre == 0) begin res_q.push_back(32'h0); m_uf = 1; end
         else begin res_q.push_back(exp_q.pop_front()); m_rd = (m_rd + 1) % m_size; end
      end
      if (pu) begin
         if (pre == m_size) m_of = 1;
         else begin exp_q.push_back(d); m_wr = (m_wr + 1) % m_size; end
      end
      @(posedge clk); #1;
      push_valid = 0; pop_req = 0;
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [31:0] d, input bit pu);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d; push_valid = pu; push_data = 32'hDEAD0000;
      @(posedge clk); #1;
      reg_wr = 0; push_valid = 0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
      reg_addr = a; #1; v = reg_rdata;
   endtask

   task automatic cfg_write(input int ne, input int nf, input int bs, input int es, input bit pu);
      logic [31:0] w;
      w = (32'(nf) << 29) | (32'(ne) << 26) | (32'(bs) << 24) | (32'(es) << 22) | 32'h0000_3FFF;
      wr_reg(2'd0, w, pu);
      m_ne = ne; m_nf = nf; m_bs = bs; m_es = es; m_size = 16 << bs;
      exp_q.delete(); m_wr = 0; m_rd = 0; m_uf = 0; m_of = 0;
   endtask

   task automatic check_regs(input string req);
      logic [31:0] v, e;
      int c;
      bit emp, nem, nfu, ful;
      c = exp_q.size();
      emp = (c == 0);
      nem = (c <= (1 << m_ne) - 1);
      nfu = ((m_size - c) <= (1 << m_nf) - 1);
      ful = (c == m_size);
      e = {26'd0, m_of, m_uf, ful, nfu, nem, emp};
      rd_reg(2'd1, v);
      check(v === e, {req, " status"}, v, e);
      e = (32'(m_nf) << 29) | (32'(m_ne) << 26) | (32'(m_bs) << 24) | (32'(m_es) << 22) |
          (32'(m_rd) << 7) | 32'(m_wr);
      rd_reg(2'd0, v);
      check(v === e, {req, " config/pointers"}, v, e);
   endtask

   task automatic check_irq(input bit e, input string req);
      check(irq === e, req, {31'd0, irq}, {31'd0, e});
   endtask

   initial begin
      #2_000_000;
      checks++; errors++;
      $display("FAIL R2 watchdog expired actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd_reg(2'd1, v); check(v === 32'h3, "R1 status reset", v, 32'h3);
      rd_reg(2'd0, v); check(v === 32'h0, "R1 config reset", v, 32'h0);
      rd_reg(2'd2, v); check(v === 32'h0, "R1 irq control reset", v, 32'h0);
      rd_reg(2'd3, v); check(v === 32'h1, "R1 irq status reset", v, 32'h1);
      check_irq(1'b0, "R1 irq low after reset");
      check(pop_valid === 1'b0, "R1 pop_valid reset", {31'd0, pop_valid}, 32'h0);

      // R2 ordering with default configuration
      for (int i = 0; i < 3; i++) step(1, 32'hA000_0000 + i, 0);
      check_regs("R2 R7 after three pushes");
      for (int i = 0; i < 3; i++) step(0, 0, 1);
      check_regs("R2 drained");

      // R5 R6 R7 R3: 16 words, NE=2 (limit 3), NF=1 (limit 1)
      cfg_write(2, 1, 0, 0, 0);
      check_regs("R10 R5 after config");
      for (int i = 0; i < 17; i++) begin
         step(1, 32'hB000_0000 + i, 0);
         check_regs("R3 R5 R6 R7 fill");
      end
      for (int i = 0; i < 17; i++) begin
         step(0, 0, 1);
         check_regs("R4 R5 R6 R7 drain");
      end

      // R10: config write colliding with a push
      step(1, 32'hC000_0001, 0);
      step(1, 32'hC000_0002, 0);
      cfg_write(0, 0, 1, 2, 1);
      check_regs("R10 config write drops push and clears flags");

      // R11: push and pop together on empty, then on partly filled
      step(1, 32'hD000_0001, 1);
      check_regs("R11 push with pop on empty");
      step(1, 32'hD000_0002, 0);
      step(1, 32'hD000_0003, 1);
      check_regs("R11 push with pop keeps count");

      // count now 2 of 32; R8 R9 interrupt sources
      wr_reg(2'd2, 32'h8, 0);                       // enable, source 0
      check_irq(1'b1, "R9 reset status shows once enabled");
      wr_reg(2'd3, 32'h1, 0);
      check_irq(1'b0, "R9 write-one clears status");
      step(0, 0, 1); step(0, 0, 0);
      check_irq(1'b0, "R8 source 0 not empty after read");
      step(0, 0, 1); step(0, 0, 0);
      check_irq(1'b1, "R8 source 0 empty after read");

      wr_reg(2'd2, 32'hC, 0);                       // enable, source 4
      wr_reg(2'd3, 32'h1, 0);
      step(0, 0, 1); step(0, 0, 0);
      check_irq(1'b0, "R8 source 4 ignores a read");
      step(1, 32'hE000_0001, 0); step(0, 0, 0);
      check_irq(1'b1, "R8 source 4 not empty after write");

      wr_reg(2'd2, 32'hB, 0);                       // enable, source 3
      wr_reg(2'd3, 32'h1, 0);
      step(1, 32'hE000_0002, 0); step(0, 0, 0);
      check_irq(1'b0, "R8 source 3 not full after write");

      wr_reg(2'd2, 32'hF, 0);                       // enable, source 7
      wr_reg(2'd3, 32'h1, 0);
      step(0, 0, 1); step(0, 0, 0);
      check_irq(1'b1, "R8 source 7 not full after read");

      wr_reg(2'd2, 32'h4, 0);                       // disabled, source 4
      wr_reg(2'd3, 32'h1, 0);
      step(1, 32'hE000_0003, 0); step(0, 0, 0);
      check_irq(1'b0, "R9 disabled keeps irq low");
      rd_reg(2'd3, v); check(v === 32'h1, "R9 status set while disabled", v, 32'h1);
      check_regs("R2 R11 final");

      step(0, 0, 0);
      check(res_q.size() == 0, "R2 all pops returned", 32'(res_q.size()), 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule